// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock. It fetches a word from an internal read-only instruction array at the program counter, decodes it, reads two operands from a 32-entry register file, computes in an ALU, optionally touches an internal data array, and writes a result back, all in the same cycle. The next program counter is either the following word, a branch target or a jump target.

The instruction set is a small load/store subset: word load, word store, the register-register operations add, subtract, and, or and signed set-less-than, an equality branch and an absolute jump. Both memories are plain internal arrays that a testbench fills before reset is released. The retiring instruction's register write and memory write are brought out on ports so that an observer can follow execution.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low the program counter is 0, and the first instruction after release is fetched from address 0.
- R2: Every instruction is 4 bytes; unless a taken branch or a jump applies, the next PC is the current PC plus 4.
- R3: Opcode 0x23 (load word) adds the sign-extended 16-bit offset (bits 15:0) to register rs (bits 25:21) and writes the data word at that address into register rt (bits 20:16).
- R4: Opcode 0x2B (store word) forms its address the same way and writes register rt to data memory at that address; it asserts no register write.
- R5: Opcode 0x00 selects a register operation chosen by bits 5:0: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or; the result goes to register rd (bits 15:11).
- R6: Function 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, otherwise 0.
- R7: Register 0 always reads as zero; a write addressed to it has no effect.
- R8: Opcode 0x04 (branch-if-equal) compares rs and rt; when equal the next PC is the branch's own address plus the sign-extended offset shifted left by 2, otherwise PC plus 4. It writes nothing.
- R9: Opcode 0x02 (jump) sets the PC to the current PC bits 31:28, then instruction bits 25:0, then two zero bits.
- R10: Both memories are word-indexed by address bits above bit 1, modulo their depth; address bits 1:0 and bits above the depth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | Register write enable of this instruction |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Value written to the register file |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_addr_o | output | 32 | Data memory byte address |
| dmem_wdata_o | output | 32 | Data memory write value |

## Verification
The bench targets the branch target base, where a core that adds the offset to PC plus 4 lands one word late after a taken branch, and the jump, where using the incremented PC or dropping the upper PC bits sends execution elsewhere. It drives set-less-than with operands of opposite sign, which an unsigned compare gets backwards, and writes to register 0 followed by reads of it, which a file without the zero guard returns as stale data. Loads and stores use negative offsets and unaligned or wrapping addresses, exposing a missing sign extension or wrong index slice as wrong load data on the write-back port.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    ALUOP_ADD   = 2'b00,
    ALUOP_SUB   = 2'b01,
    ALUOP_FUNCT = 2'b10
  } alu_op_e;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic    dst_rd;
    logic    src_imm;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o,
  output alu_fn_e    alu_fn_o
);

  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALUOP_ADD;
    case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.dst_rd    = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = ALUOP_FUNCT;
      end
      OP_LW: begin
        ctrl_o.src_imm    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_read   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.src_imm   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALUOP_SUB;
      end
      OP_J: ctrl_o.jump = 1'b1;
      default: ;
    endcase
  end

  // second-level ALU decode
  always_comb begin
    case (ctrl_o.alu_op)
      ALUOP_SUB:   alu_fn_o = ALU_SUB;
      ALUOP_FUNCT: begin
        case (funct_i)
          FN_SUB:  alu_fn_o = ALU_SUB;
          FN_AND:  alu_fn_o = ALU_AND;
          FN_OR:   alu_fn_o = ALU_OR;
          FN_SLT:  alu_fn_o = ALU_SLT;
          default: alu_fn_o = ALU_ADD;
        endcase
      end
      default:     alu_fn_o = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      fn_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);

  always_comb begin
    case (fn_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  da_o,
  output logic [W-1:0]  db_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);

  logic [W-1:0] regs_q [NREG];

  // entry 0 is never written and reads back as zero
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[g] <= '0;
        else         regs_q[g] <= '0;
      end
    end else begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          regs_q[g] <= '0;
        else if (we_i && wa_i == AW'(g))      regs_q[g] <= wd_i;
      end
    end
  end

  assign da_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign db_o = (rb_i == '0) ? '0 : regs_q[rb_i];

endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] idx_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dmem_we_o,
  output logic [31:0] dmem_addr_o,
  output logic [31:0] dmem_wdata_o
);

  logic [XLEN-1:0] pc_q, pc_next, pc_seq, pc_br, pc_jmp;
  logic [XLEN-1:0] instr, rs_data, rt_data, imm_ext, alu_b, alu_y;
  logic [XLEN-1:0] dmem_rdata, load_data, wb_data;
  logic [4:0]      waddr;
  logic            zero, take_br;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  sc_ram #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
    .clk_i   (clk_i),
    .we_i    (1'b0),
    .idx_i   (pc_q[IAW+1:2]),
    .wdata_i ('0),
    .rdata_o (instr)
  );

  sc_decoder u_dec (
    .opcode_i (instr[31:26]),
    .funct_i  (instr[5:0]),
    .ctrl_o   (ctrl),
    .alu_fn_o (alu_fn)
  );

  assign waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];

  sc_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (instr[25:21]),
    .rb_i   (instr[20:16]),
    .da_o   (rs_data),
    .db_o   (rt_data),
    .we_i   (ctrl.reg_write),
    .wa_i   (waddr),
    .wd_i   (wb_data)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_data;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_data),
    .b_i    (alu_b),
    .fn_i   (alu_fn),
    .y_o    (alu_y),
    .zero_o (zero)
  );

  sc_ram #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (ctrl.mem_write),
    .idx_i   (alu_y[DAW+1:2]),
    .wdata_i (rt_data),
    .rdata_o (dmem_rdata)
  );

  assign load_data = ctrl.mem_read ? dmem_rdata : '0;
  assign wb_data   = ctrl.mem_to_reg ? load_data : alu_y;

  // branch base is the branch's own address
  assign pc_seq  = pc_q + 32'd4;
  assign pc_br   = pc_q + {imm_ext[XLEN-3:0], 2'b00};
  assign pc_jmp  = {pc_q[31:28], instr[25:0], 2'b00};
  assign take_br = ctrl.branch & zero;

  always_comb begin
    if (ctrl.jump)    pc_next = pc_jmp;
    else if (take_br) pc_next = pc_br;
    else              pc_next = pc_seq;
  end

  assign pc_o         = pc_q;
  assign instr_o      = instr;
  assign rf_we_o      = ctrl.reg_write;
  assign rf_waddr_o   = waddr;
  assign rf_wdata_o   = wb_data;
  assign dmem_we_o    = ctrl.mem_write;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_data;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_o,
  input logic [31:0] instr_o,
  input logic [31:0] rs_data,
  input logic        rf_we_o,
  input logic        dmem_we_o,
  input logic        zero
);

  logic is_br, is_j;
  assign is_br = (instr_o[31:26] == 6'h04);
  assign is_j  = (instr_o[31:26] == 6'h02);

  // R2
  pc_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_j && !(is_br && zero)) |=> pc_o == $past(pc_o) + 32'd4);

  // R8
  br_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_br && zero) |=> pc_o == $past(pc_o) + {{14{$past(instr_o[15])}}, $past(instr_o[15:0]), 2'b00});

  // R9
  jmp_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_j |=> pc_o == {$past(pc_o[31:28]), $past(instr_o[25:0]), 2'b00});

  // R7
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_o[25:21] == 5'd0) |-> rs_data == 32'd0);

  // R4
  store_no_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> !rf_we_o);

  // R8
  br_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_br |-> !rf_we_o && !dmem_we_o);

endmodule

bind sc_core sc_core_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_o      (pc_o),
  .instr_o   (instr_o),
  .rs_data   (rs_data),
  .rf_we_o   (rf_we_o),
  .dmem_we_o (dmem_we_o),
  .zero      (zero)
);

// File: tb/test_sc_core.sv
module test_sc_core;

  localparam int IW = 256;
  localparam int DW = 64;
  localparam int EPISODES = 8;
  localparam int CYCLES = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc, instr, rf_wdata, dmem_addr, dmem_wdata;
  logic [4:0]  rf_waddr;
  logic        rf_we, dmem_we;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_reg  [32];
  logic [31:0] m_dmem [DW];
  logic [31:0] m_imem [IW];
  logic [31:0] m_pc;

  always #10 clk = ~clk;

  sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_sc_core (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pc_o         (pc),
    .instr_o      (instr),
    .rf_we_o      (rf_we),
    .rf_waddr_o   (rf_waddr),
    .rf_wdata_o   (rf_wdata),
    .dmem_we_o    (dmem_we),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [31:0] rand_instr();
    int sel = $urandom % 100;
    logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
    if (sel < 50) return enc_r($urandom % 32, $urandom % 32, $urandom % 32, fns[$urandom % 5]);
    if (sel < 65) return enc_i(6'h23, $urandom % 32, $urandom % 32, int'($urandom % 512) - 256);
    if (sel < 80) return enc_i(6'h2B, $urandom % 32, $urandom % 32, int'($urandom % 512) - 256);
    if (sel < 92) return enc_i(6'h04, $urandom % 8, $urandom % 8, 1 + ($urandom % 6));
    return {6'h02, 26'($urandom % IW)};
  endfunction

  // reference step: compare ports against the model, then advance the model
  task automatic step();
    logic [31:0] ins = m_imem[m_pc[9:2]];
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    int rs = ins[25:21], rt = ins[20:16], rd = ins[15:11];
    logic [31:0] a = m_reg[rs], b = m_reg[rt];
    logic [31:0] nxt = m_pc + 32'd4;
    logic        we = 1'b0, mw = 1'b0;
    logic [4:0]  wa = 5'd0;
    logic [31:0] wd = '0, ad = '0;
    string       rq;
    string       pq = "R2";
    case (op)
      6'h00: begin
        we = 1'b1; wa = 5'(rd);
        case (fn)
          6'h22: wd = a - b;
          6'h24: wd = a & b;
          6'h25: wd = a | b;
          6'h2A: wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: wd = a + b;
        endcase
      end
      6'h23: begin
        ad = a + sx(ins[15:0]);
        we = 1'b1; wa = 5'(rt); wd = m_dmem[ad[7:2]];
      end
      6'h2B: begin
        ad = a + sx(ins[15:0]);
        mw = 1'b1;
      end
      6'h04: begin
        pq = "R8";
        if (a == b) nxt = m_pc + {sx(ins[15:0])[29:0], 2'b00};
      end
      6'h02: begin
        pq = "R9";
        nxt = {m_pc[31:28], ins[25:0], 2'b00};
      end
      default: ;
    endcase
    rq = (op == 6'h23) ? "R3 R10" : (op == 6'h00 && fn == 6'h2A) ? "R6" :
         (op == 6'h00 && (rs == 0 || rt == 0)) ? "R7" : "R5";

    check(pc == m_pc, pq, "pc", pc, m_pc);
    check(rf_we == we, (op == 6'h2B) ? "R4" : rq, "reg write enable", 32'(rf_we), 32'(we));
    if (we) begin
      check(rf_waddr == wa, rq, "dest reg", 32'(rf_waddr), 32'(wa));
      check(rf_wdata == wd, rq, "write data", rf_wdata, wd);
    end
    check(dmem_we == mw, "R4", "store enable", 32'(dmem_we), 32'(mw));
    if (mw) begin
      check(dmem_addr == ad, "R4", "store address", dmem_addr, ad);
      check(dmem_wdata == b, "R4", "store data", dmem_wdata, b);
    end

    if (we && wa != 5'd0) m_reg[wa] = wd;
    if (mw) m_dmem[ad[7:2]] = b;
    m_pc = nxt;
  endtask

  task automatic load_program(input int ep);
    for (int i = 0; i < IW; i++) m_imem[i] = rand_instr();
    for (int i = 0; i < DW; i++) m_dmem[i] = $urandom;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    if (ep == 0) begin
      m_dmem[0] = 32'hFFFF_FFF0;
      m_dmem[1] = 32'd5;
      m_dmem[2] = 32'h20;
      m_imem[0]  = enc_i(6'h23, 0, 1, 0);       // r1 = -16
      m_imem[1]  = enc_i(6'h23, 0, 2, 4);       // r2 = 5
      m_imem[2]  = enc_r(1, 2, 3, 6'h2A);       // R6 signed: 1
      m_imem[3]  = enc_r(2, 1, 4, 6'h2A);       // R6 signed: 0
      m_imem[4]  = enc_r(1, 2, 0, 6'h20);       // R7 write to r0
      m_imem[5]  = enc_r(0, 2, 5, 6'h20);       // R7 r5 = 0 + 5
      m_imem[6]  = enc_i(6'h23, 0, 6, 8);       // r6 = 0x20
      m_imem[7]  = enc_i(6'h23, 6, 7, -4);      // R3 negative offset
      m_imem[8]  = enc_i(6'h2B, 6, 2, -8);      // R4 store to 0x18
      m_imem[9]  = enc_i(6'h04, 2, 5, 3);       // R8 taken: 36+12 = 48
      m_imem[10] = enc_r(1, 2, 8, 6'h22);
      m_imem[11] = enc_r(1, 2, 9, 6'h22);
      m_imem[12] = {6'h02, 26'd20};             // R9 to 80
      m_imem[13] = enc_i(6'h23, 0, 10, 24);
      m_imem[20] = enc_i(6'h23, 0, 11, 27);     // R10 unaligned: word 6
      m_imem[21] = enc_i(6'h23, 0, 12, 256+4);  // R10 wraps to word 1
      m_imem[22] = enc_i(6'h04, 0, 0, 2);       // R8 equal zeros: 88+8 = 96
    end
    m_pc = '0;
    for (int i = 0; i < IW; i++) i_sc_core.u_imem.mem_q[i] = m_imem[i];
    for (int i = 0; i < DW; i++) i_sc_core.u_dmem.mem_q[i] = m_dmem[i];
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int ep = 0; ep < EPISODES; ep++) begin
      @(negedge clk);
      rst_n = 1'b0;
      load_program(ep);
      @(negedge clk);
      check(pc == 32'd0, "R1", "pc in reset", pc, 32'd0);
      rst_n = 1'b1;
      for (int c = 0; c < CYCLES; c++) begin
        #1;
        step();
        @(negedge clk);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (EPISODES * (CYCLES + 4) + 200) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule